// File: doc/BRIEF.md
# Interprocessor Interrupt Command Unit

This block gives a processor a memory-mapped way to send an interrupt message to other processors. Software first writes a destination identifier into the upper command word. It then writes the lower command word, which holds the vector, the delivery type, the trigger and level bits and a destination shorthand. The write to the lower word is what launches the message. While the message waits on the outgoing bus, the lower word reads back with a busy bit set, so software can poll until the send has gone.

The outgoing message is a single beat on a valid/ready bus. Every field is latched when the message is launched and stays fixed until the consumer takes it. A shorthand other than "explicit" replaces the destination field: it selects the unit's own identifier or the broadcast identifier.

Send-side problems are collected in an error accumulator. These are a bus-reported failure, a write during a busy send, a forbidden vector and an access to an unmapped offset. Any write to the error register moves the accumulated flags into its readable value and clears the accumulator.

Top module: `ipi_cmd_unit`

## Requirements
- R1: After reset `msg_valid` is 0. The lower word (offset 0x300), the upper word (offset 0x310) and the error register (offset 0x280) all read 0.
- R2: A write to offset 0x310 keeps bits [31:24] as the destination identifier. Reads return that byte in [31:24] and zeros in all other bits.
- R3: A write to offset 0x300 while idle, with an allowed vector, sets `msg_valid` in the next cycle. From that cycle the lower word reads back with bit 12 (busy) set to 1.
- R4: The launched message carries the vector from [7:0], the delivery type from [10:8], the level bit from bit 14 (1 = assert), the trigger bit from bit 15 and the shorthand from [19:18] of the written lower word. Reads of the lower word return exactly these bits plus bit 12.
- R5: The message destination follows the shorthand. Code 0 uses the upper-word identifier. Code 1 uses the `self_id` input. Codes 2 (all including self) and 3 (all excluding self) use 8'hFF.
- R6: While `msg_valid` is 1 and `msg_ready` is 0, every message field holds its value. This is true even when the upper word is rewritten.
- R7: A cycle with `msg_valid` and `msg_ready` both 1 completes the send. In the next cycle `msg_valid` is 0 and lower-word bit 12 reads 0.
- R8: A write to the lower word while busy changes neither the stored lower word nor the pending message, launches nothing, and sets error bit 2.
- R9: A lower-word write with delivery type 0 (fixed) and a vector below 16 launches nothing and sets error bit 5. Other delivery types accept any vector.
- R10: A read or write to any offset other than 0x300, 0x310 and 0x280 sets error bit 7.
- R11: If `msg_err` is 1 in the cycle that completes a send, error bit 0 is set.
- R12: A write to offset 0x280 copies the accumulated flags into the readable error value and clears the accumulator. A second write with no new errors in between makes the readable value 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| self_id | input | 8 | This unit's own identifier, used by the self shorthand |
| reg_we | input | 1 | Register write strobe |
| reg_re | input | 1 | Register read strobe |
| reg_addr | input | 12 | Register byte offset |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data, combinational from `reg_addr` |
| msg_valid | output | 1 | Message beat is present |
| msg_ready | input | 1 | Bus takes the beat |
| msg_err | input | 1 | Bus reports a failed send, sampled with the handshake |
| msg_dest | output | 8 | Resolved destination identifier |
| msg_shorthand | output | 2 | Destination shorthand code |
| msg_trigger | output | 1 | Trigger mode bit (1 = level) |
| msg_level | output | 1 | Level assert (1) or deassert (0) |
| msg_mode | output | 3 | Delivery type |
| msg_vector | output | 8 | Vector or start page |

## Verification
A register write takes effect at the clock edge that samples it. The message fields, `msg_valid`, the busy bit and the error accumulator all change at that same edge. The bench therefore drives each write at a falling edge and reads the results at the following falling edge. A completed handshake clears `msg_valid` one edge later. Error flags become visible only after a write to the error register, so the bench always reads them with a write to 0x280 followed by a read one cycle later. The reads are combinational, and the bench samples them 1 ns after setting the address.

// File: rtl/ipi_pkg.sv
package ipi_pkg;

  localparam int REG_W = 32;
  localparam int ID_W  = 8;
  localparam int VEC_W = 8;
  localparam int ESR_W = 8;

  // Writable bits of the lower command word: [19:18],[15],[14],[10:8],[7:0]
  localparam logic [REG_W-1:0] LO_MASK  = 32'h000C_C7FF;
  localparam int               BUSY_BIT = 12;

  localparam logic [2:0] MODE_FIXED = 3'b000;

  localparam logic [1:0] SH_NONE   = 2'd0;
  localparam logic [1:0] SH_SELF   = 2'd1;
  localparam logic [1:0] SH_ALL    = 2'd2;
  localparam logic [1:0] SH_OTHERS = 2'd3;

  localparam int ERR_SEND_CS  = 0;
  localparam int ERR_SEND_ACC = 2;
  localparam int ERR_SEND_VEC = 5;
  localparam int ERR_BAD_REG  = 7;

  typedef struct packed {
    logic [ID_W-1:0]  dest;
    logic [1:0]       shorthand;
    logic             trigger;
    logic             level;
    logic [2:0]       mode;
    logic [VEC_W-1:0] vector;
  } ipi_msg_t;

  function automatic logic [ID_W-1:0] pick_dest(input logic [1:0] sh,
                                                input logic [ID_W-1:0] field,
                                                input logic [ID_W-1:0] own,
                                                input logic [ID_W-1:0] bcast);
    case (sh)
      SH_NONE: pick_dest = field;
      SH_SELF: pick_dest = own;
      default: pick_dest = bcast;
    endcase
  endfunction

  function automatic logic vector_forbidden(input logic [2:0] mode,
                                            input logic [VEC_W-1:0] vec,
                                            input logic [VEC_W-1:0] floor_v);
    vector_forbidden = (mode == MODE_FIXED) && (vec < floor_v);
  endfunction

  function automatic ipi_msg_t decode_low(input logic [REG_W-1:0] lo,
                                          input logic [ID_W-1:0] dest);
    ipi_msg_t m;
    m.dest      = dest;
    m.shorthand = lo[19:18];
    m.trigger   = lo[15];
    m.level     = lo[14];
    m.mode      = lo[10:8];
    m.vector    = lo[7:0];
    decode_low  = m;
  endfunction

endpackage

// File: rtl/ipi_regs.sv
module ipi_regs
  import ipi_pkg::*;
#(
  parameter int                ADDR_W  = 12,
  parameter logic [ADDR_W-1:0] OFF_LO  = ADDR_W'('h300),
  parameter logic [ADDR_W-1:0] OFF_HI  = ADDR_W'('h310),
  parameter logic [ADDR_W-1:0] OFF_ERR = ADDR_W'('h280)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [REG_W-1:0]  reg_wdata,
  input  logic              busy,
  input  logic [ESR_W-1:0]  err_view,
  output logic [ID_W-1:0]   hi_id,
  output logic              wr_lo,
  output logic              wr_err,
  output logic              bad_access,
  output logic [REG_W-1:0]  reg_rdata
);

  logic hit_lo, hit_hi, hit_err;
  logic [REG_W-1:0] lo_q;

  assign hit_lo     = (reg_addr == OFF_LO);
  assign hit_hi     = (reg_addr == OFF_HI);
  assign hit_err    = (reg_addr == OFF_ERR);
  assign wr_lo      = reg_we && hit_lo;
  assign wr_err     = reg_we && hit_err;
  assign bad_access = (reg_we || reg_re) && !(hit_lo || hit_hi || hit_err);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hi_id <= '0;
      lo_q  <= '0;
    end else begin
      if (reg_we && hit_hi) hi_id <= reg_wdata[REG_W-1 -: ID_W];
      if (wr_lo && !busy)   lo_q  <= reg_wdata & LO_MASK;
    end
  end

  always_comb begin
    reg_rdata = '0;
    if (hit_lo) begin
      reg_rdata           = lo_q;
      reg_rdata[BUSY_BIT] = busy;
    end else if (hit_hi) begin
      reg_rdata[REG_W-1 -: ID_W] = hi_id;
    end else if (hit_err) begin
      reg_rdata[ESR_W-1:0] = err_view;
    end
  end

endmodule

// File: rtl/ipi_launch.sv
module ipi_launch
  import ipi_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     launch,
  input  ipi_msg_t msg_in,
  input  logic     msg_ready,
  input  logic     msg_err,
  output logic     busy,
  output ipi_msg_t msg_q,
  output logic     done,
  output logic     done_err
);

  assign done     = busy && msg_ready;
  assign done_err = done && msg_err;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy  <= 1'b0;
      msg_q <= '0;
    end else if (launch) begin
      busy  <= 1'b1;
      msg_q <= msg_in;
    end else if (done) begin
      busy  <= 1'b0;
    end
  end

endmodule

// File: rtl/ipi_err.sv
module ipi_err
  import ipi_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic [ESR_W-1:0] events,
  input  logic             snap,
  output logic [ESR_W-1:0] acc,
  output logic [ESR_W-1:0] view
);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc  <= '0;
      view <= '0;
    end else if (snap) begin
      view <= acc;
      acc  <= events;
    end else begin
      acc  <= acc | events;
    end
  end

endmodule

// File: rtl/ipi_cmd_unit.sv
module ipi_cmd_unit
  import ipi_pkg::*;
#(
  parameter int                ADDR_W   = 12,
  parameter logic [ADDR_W-1:0] OFF_LO   = ADDR_W'('h300),
  parameter logic [ADDR_W-1:0] OFF_HI   = ADDR_W'('h310),
  parameter logic [ADDR_W-1:0] OFF_ERR  = ADDR_W'('h280),
  parameter logic [7:0]        MIN_VEC  = 8'd16,
  parameter logic [7:0]        BCAST_ID = 8'hFF
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [7:0]        self_id,
  input  logic              reg_we,
  input  logic              reg_re,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [31:0]       reg_wdata,
  output logic [31:0]       reg_rdata,
  output logic              msg_valid,
  input  logic              msg_ready,
  input  logic              msg_err,
  output logic [7:0]        msg_dest,
  output logic [1:0]        msg_shorthand,
  output logic              msg_trigger,
  output logic              msg_level,
  output logic [2:0]        msg_mode,
  output logic [7:0]        msg_vector
);

  logic [ID_W-1:0]  hi_id;
  logic             wr_lo, wr_err, bad_access;
  logic             lo_illegal, launch, done, done_err;
  logic [ESR_W-1:0] err_events, esr_acc, esr_view;
  ipi_msg_t         msg_next, msg_q;

  ipi_regs #(
    .ADDR_W(ADDR_W), .OFF_LO(OFF_LO), .OFF_HI(OFF_HI), .OFF_ERR(OFF_ERR)
  ) u_regs (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .busy(msg_valid),
    .err_view(esr_view), .hi_id(hi_id), .wr_lo(wr_lo), .wr_err(wr_err),
    .bad_access(bad_access), .reg_rdata(reg_rdata)
  );

  assign lo_illegal = vector_forbidden(reg_wdata[10:8], reg_wdata[7:0], MIN_VEC);
  assign msg_next   = decode_low(reg_wdata,
                                 pick_dest(reg_wdata[19:18], hi_id, self_id, BCAST_ID));
  assign launch     = wr_lo && !msg_valid && !lo_illegal;

  ipi_launch u_launch (
    .clk(clk), .rst_n(rst_n), .launch(launch), .msg_in(msg_next),
    .msg_ready(msg_ready), .msg_err(msg_err), .busy(msg_valid),
    .msg_q(msg_q), .done(done), .done_err(done_err)
  );

  always_comb begin
    err_events               = '0;
    err_events[ERR_SEND_CS]  = done_err;
    err_events[ERR_SEND_ACC] = wr_lo && msg_valid;
    err_events[ERR_SEND_VEC] = wr_lo && !msg_valid && lo_illegal;
    err_events[ERR_BAD_REG]  = bad_access;
  end

  ipi_err u_err (
    .clk(clk), .rst_n(rst_n), .events(err_events), .snap(wr_err),
    .acc(esr_acc), .view(esr_view)
  );

  assign msg_dest      = msg_q.dest;
  assign msg_shorthand = msg_q.shorthand;
  assign msg_trigger   = msg_q.trigger;
  assign msg_level     = msg_q.level;
  assign msg_mode      = msg_q.mode;
  assign msg_vector    = msg_q.vector;

endmodule

// File: rtl/ipi_cmd_unit_chk.sv
module ipi_cmd_unit_chk
  import ipi_pkg::*;
(
  input logic             clk,
  input logic             rst_n,
  input logic             msg_valid,
  input logic             msg_ready,
  input ipi_msg_t         msg_q,
  input logic             wr_lo,
  input logic             lo_illegal,
  input logic             bad_access,
  input logic             wr_err,
  input logic [ESR_W-1:0] esr_acc,
  input logic [ESR_W-1:0] esr_view
);

  a_r3_launch: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && !msg_valid && !lo_illegal |=> msg_valid);

  a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && !msg_ready |=> msg_valid && $stable(msg_q));

  a_r7_complete: assert property (@(posedge clk) disable iff (!rst_n)
    msg_valid && msg_ready |=> !msg_valid);

  a_r8_busy_write: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && msg_valid |=> esr_acc[ERR_SEND_ACC]);

  a_r8_busy_keep: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && msg_valid && !msg_ready |=> $stable(msg_q));

  a_r9_bad_vector: assert property (@(posedge clk) disable iff (!rst_n)
    wr_lo && !msg_valid && lo_illegal |=> !msg_valid && esr_acc[ERR_SEND_VEC]);

  a_r10_bad_reg: assert property (@(posedge clk) disable iff (!rst_n)
    bad_access |=> esr_acc[ERR_BAD_REG]);

  a_r12_snapshot: assert property (@(posedge clk) disable iff (!rst_n)
    wr_err |=> esr_view == $past(esr_acc));

endmodule

bind ipi_cmd_unit ipi_cmd_unit_chk u_chk (
  .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_ready(msg_ready),
  .msg_q(msg_q), .wr_lo(wr_lo), .lo_illegal(lo_illegal),
  .bad_access(bad_access), .wr_err(wr_err), .esr_acc(esr_acc),
  .esr_view(esr_view)
);

// File: tb/ipi_cmd_unit_bench.sv
`timescale 1ns/1ps
module ipi_cmd_unit_bench;

  localparam logic [11:0] A_LO  = 12'h300;
  localparam logic [11:0] A_HI  = 12'h310;
  localparam logic [11:0] A_ERR = 12'h280;
  localparam logic [7:0]  SELF  = 8'h2C;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_we = 1'b0, reg_re = 1'b0;
  logic [11:0] reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic        msg_valid, msg_ready = 1'b0, msg_err = 1'b0;
  logic [7:0]  msg_dest, msg_vector;
  logic [1:0]  msg_shorthand;
  logic        msg_trigger, msg_level;
  logic [2:0]  msg_mode;

  int checks = 0;
  int failures = 0;

  always #4 clk = ~clk;

  ipi_cmd_unit u_ipi_cmd_unit (
    .clk(clk), .rst_n(rst_n), .self_id(SELF), .reg_we(reg_we), .reg_re(reg_re),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .msg_valid(msg_valid), .msg_ready(msg_ready), .msg_err(msg_err),
    .msg_dest(msg_dest), .msg_shorthand(msg_shorthand),
    .msg_trigger(msg_trigger), .msg_level(msg_level),
    .msg_mode(msg_mode), .msg_vector(msg_vector)
  );

  task automatic chk(input logic ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rd(input logic [11:0] a, output logic [31:0] d);
    reg_re = 1'b1; reg_addr = a;
    #1 d = reg_rdata;
    @(negedge clk);
    reg_re = 1'b0;
  endtask

  task automatic take(input logic err);
    msg_ready = 1'b1; msg_err = err;
    @(negedge clk);
    msg_ready = 1'b0; msg_err = 1'b0;
  endtask

  task automatic fetch_err(output logic [31:0] d);
    wr(A_ERR, 32'h0);
    rd(A_ERR, d);
  endtask

  function automatic logic [31:0] lo_word(input logic [1:0] sh, input logic trg,
                                          input logic lvl, input logic [2:0] md,
                                          input logic [7:0] v);
    return (32'(sh) << 18) | (32'(trg) << 15) | (32'(lvl) << 14) |
           (32'(md) << 8) | 32'(v);
  endfunction

  function automatic logic [7:0] want_dest(input logic [1:0] sh, input logic [7:0] f);
    if (sh == 2'd0) return f;
    if (sh == 2'd1) return SELF;
    return 8'hFF;
  endfunction

  initial begin
    #(8ns * 200000);
    failures++;
    $display("FAIL watchdog actual=%h expected=%h", 32'd0, 32'd1);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [31:0] w;
    logic [7:0]  dest;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    chk(msg_valid == 1'b0, "R1 valid", 32'(msg_valid), 0);
    rd(A_LO, d);  chk(d == 0, "R1 lo", d, 0);
    rd(A_HI, d);  chk(d == 0, "R1 hi", d, 0);
    rd(A_ERR, d); chk(d == 0, "R1 err", d, 0);

    // R2 upper word keeps only [31:24]
    wr(A_HI, 32'hA5FF_FFFF);
    rd(A_HI, d); chk(d == 32'hA500_0000, "R2 hi readback", d, 32'hA500_0000);

    // R3 R4 R5 R6 R7 sweep over shorthand x delivery type x level/trigger
    for (int i = 0; i < 24; i++) begin
      logic [1:0] sh;
      logic [2:0] md;
      logic [7:0] v;
      sh   = 2'(i % 4);
      md   = (i / 4 % 3 == 0) ? 3'd0 : ((i / 4 % 3 == 1) ? 3'd5 : 3'd6);
      v    = 8'h40 + 8'(i * 5);
      dest = 8'h11 + 8'(i * 9);
      w    = lo_word(sh, i[4], i[0], md, v);
      wr(A_HI, {dest, 24'h0});
      wr(A_LO, w);
      chk(msg_valid == 1'b1, "R3 valid", 32'(msg_valid), 1);
      rd(A_LO, d);
      chk(d == (w | 32'h1000), "R3 R4 lo busy readback", d, w | 32'h1000);
      chk({msg_shorthand, msg_trigger, msg_level, msg_mode, msg_vector} ==
          {sh, i[4], i[0], md, v}, "R4 fields",
          32'({msg_shorthand, msg_trigger, msg_level, msg_mode, msg_vector}),
          32'({sh, i[4], i[0], md, v}));
      chk(msg_dest == want_dest(sh, dest), "R5 dest", 32'(msg_dest),
          32'(want_dest(sh, dest)));
      wr(A_HI, 32'h7700_0000);
      @(negedge clk);
      chk(msg_valid && msg_dest == want_dest(sh, dest) && msg_vector == v,
          "R6 hold", 32'(msg_dest), 32'(want_dest(sh, dest)));
      take(1'b0);
      chk(msg_valid == 1'b0, "R7 valid drop", 32'(msg_valid), 0);
      rd(A_LO, d);
      chk(d == w, "R7 busy clear", d, w);
    end
    fetch_err(d);
    chk(d == 0, "R7 no errors in sweep", d, 0);

    // R8 write while busy is ignored
    wr(A_HI, 32'h3300_0000);
    w = lo_word(2'd0, 1'b1, 1'b1, 3'd0, 8'h55);
    wr(A_LO, w);
    wr(A_LO, lo_word(2'd3, 1'b0, 1'b0, 3'd6, 8'h99));
    chk(msg_vector == 8'h55 && msg_dest == 8'h33, "R8 msg kept",
        32'(msg_vector), 32'h55);
    rd(A_LO, d); chk(d == (w | 32'h1000), "R8 lo kept", d, w | 32'h1000);
    take(1'b0);
    @(negedge clk);
    chk(msg_valid == 1'b0, "R8 no second send", 32'(msg_valid), 0);
    fetch_err(d); chk(d == 32'h04, "R8 err bit2", d, 32'h04);

    // R9 sweep of all vectors in fixed mode
    for (int v = 0; v < 256; v++) begin
      wr(A_LO, lo_word(2'd0, 1'b0, 1'b0, 3'd0, 8'(v)));
      chk(msg_valid == (v >= 16), "R9 fixed vector legality", 32'(msg_valid),
          32'(v >= 16));
      if (msg_valid) take(1'b0);
    end
    fetch_err(d); chk(d == 32'h20, "R9 err bit5", d, 32'h20);
    wr(A_LO, lo_word(2'd1, 1'b0, 1'b0, 3'd6, 8'h03));
    chk(msg_valid && msg_vector == 8'h03, "R9 startup low vector sent",
        32'(msg_vector), 32'h03);
    take(1'b0);
    fetch_err(d); chk(d == 0, "R9 startup no error", d, 0);

    // R10 unmapped offsets, read and write
    rd(12'h123, d);
    fetch_err(d); chk(d == 32'h80, "R10 bad read", d, 32'h80);
    wr(12'h304, 32'h0);
    fetch_err(d); chk(d == 32'h80, "R10 bad write", d, 32'h80);

    // R11 bus error at handshake
    wr(A_LO, lo_word(2'd2, 1'b0, 1'b1, 3'd0, 8'h80));
    take(1'b1);
    fetch_err(d); chk(d == 32'h01, "R11 err bit0", d, 32'h01);

    // R12 second snapshot with nothing new reads 0
    fetch_err(d); chk(d == 0, "R12 cleared", d, 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule